// File: doc/BRIEF.md
# Line-by-Line Frame Buffer Read Sequencer

This block drives a display's frame-buffer reads one line at a time. It talks to a memory port that has a command FIFO and a read-data FIFO. Each read is a self-contained transfer. On every rising edge of horizontal blank the sequencer does three things in order:

- It holds both port interfaces in reset for a fixed number of cycles.
- It waits a short guard interval.
- It writes a four-word descriptor that asks for one line of pixel words at that line's start address.

After that it pops pixel words from the read FIFO whenever the FIFO is not empty, until exactly one line has been taken. It marks the final pop with a last-word strobe.

Each line starts from a fresh reset. Because of this, a port that has been confused by a protocol fault (for example a lost cable) can stall for at most one line. If the next blank arrives before the current line is finished, the line is dropped and a sticky underrun flag is raised. The line counter returns to zero at frame start. A frame-store offset, sampled only during vertical blank, lets software rotate between several frame stores or pan the image without tearing.

Top module: `vline_rdseq`

## Requirements
- R1: On each line the four descriptor words are written on four consecutive cycles with `cmd_wr_o` high, in the order word 0, 1, 2, 3.
- R2: Word 0 carries the line length (`line_len_i` captured at the blank edge) in bits 14:0. Bits 31:15 are zero.
- R3: Word 1 has bit 31 = 0, meaning a read. Bits 30:0 hold (base + frame offset + k × stride) mod 2^31, where k counts blank edges since the last `frame_start_i` (the first line after frame start is k = 0). Base and stride are sampled at the blank edge.
- R4: Word 2 is all zero, meaning a one-line height encoded as lines − 1. Word 3 carries the stride in bits 23:0, and its bits 31:24 are zero.
- R5: After a rising edge of `hblank_i`, `iface_rst_o` is high for exactly RST_CYC consecutive cycles, starting in the next cycle.
- R6: Exactly GUARD_CYC idle cycles separate the last reset cycle from the first command word.
- R7: `rd_pop_o` is high only after the descriptor has been written and only while `rd_empty_i` is low. It never overlaps a reset or a command cycle. Exactly `line_len` pops occur per completed line.
- R8: `rd_last_o` is high together with the final pop of a line, and in no other cycle.
- R9: The frame offset `frame_ofs_i` is sampled only while `vblank_i` is high. Changes made outside vertical blank do not affect any start address.
- R10: A rising `hblank_i` that arrives before the line's final pop abandons the line (no further pops) and sets `underrun_o`, which stays high until reset. A final pop in the same cycle as the edge completes the line and does not set the flag.
- R11: While reset is active and right after it is released, all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hblank_i | input | 1 | Horizontal blank level; its rising edge starts a line |
| vblank_i | input | 1 | Vertical blank level; enables frame-offset sampling |
| frame_start_i | input | 1 | One-cycle pulse that resets the line counter |
| base_addr_i | input | 31 | Frame base address |
| frame_ofs_i | input | 31 | Frame-store offset, taken only in vertical blank |
| stride_i | input | 24 | Address distance between lines |
| line_len_i | input | 15 | Pixel words per line (at least 1) |
| rd_empty_i | input | 1 | Read-data FIFO empty |
| iface_rst_o | output | 1 | Reset for the command and read interfaces |
| cmd_wr_o | output | 1 | Command word write strobe |
| cmd_data_o | output | 32 | Command word |
| rd_pop_o | output | 1 | Read-data FIFO pop |
| rd_last_o | output | 1 | Final pop of the line |
| underrun_o | output | 1 | Sticky: a line was abandoned unfinished |

## Verification
The interesting collision is the final pop of a line landing in the same cycle as the next horizontal blank edge: the abort and the completion compete for the sequencer. The bench holds the read FIFO empty, releases it so the pops run back to back, and raises the blank so the edge lands exactly on the fourth of four pops. It then requires four pops, one last-word strobe, an underrun flag that stays low, and a clean descriptor for the following line. A second scenario raises the blank while the FIFO is still empty. There the line must be dropped with no pops, and the flag must rise and stay high.

// File: rtl/vlr_pkg.sv
package vlr_pkg;

  localparam int AW = 31;  // start address field width
  localparam int XW = 15;  // line length field width
  localparam int SW = 24;  // stride field width

  typedef enum logic [2:0] {
    S_IDLE, S_RST, S_GRD, S_CMD, S_RD, S_DONE
  } seq_st_e;

  // start address of one line, wrapped to the address field
  function automatic logic [AW-1:0] line_addr(input logic [AW-1:0] base,
                                              input logic [AW-1:0] ofs,
                                              input logic [15:0]   line,
                                              input logic [SW-1:0] stride);
    logic [63:0] sum;
    sum = 64'(line) * 64'(stride) + 64'(base) + 64'(ofs);
    return sum[AW-1:0];
  endfunction

  // one descriptor word; word 2 is a single line encoded as zero
  function automatic logic [31:0] cmd_word(input logic [1:0]    idx,
                                           input logic [XW-1:0] xsize,
                                           input logic [AW-1:0] addr,
                                           input logic [SW-1:0] stride);
    logic [31:0] w;
    case (idx)
      2'd0:    w = {17'd0, xsize};
      2'd1:    w = {1'b0, addr};
      2'd2:    w = 32'd0;
      default: w = {8'd0, stride};
    endcase
    return w;
  endfunction

endpackage

// File: rtl/vlr_linegen.sv
module vlr_linegen
  import vlr_pkg::*;
#(
  parameter int LW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hblank_i,
  input  logic          vblank_i,
  input  logic          frame_start_i,
  input  logic [AW-1:0] base_i,
  input  logic [AW-1:0] ofs_i,
  input  logic [SW-1:0] stride_i,
  input  logic [XW-1:0] len_i,
  output logic          hb_rise,
  output logic [AW-1:0] addr_q,
  output logic [SW-1:0] stride_q,
  output logic [XW-1:0] len_q
);

  logic          hb_q;
  logic [AW-1:0] ofs_q;
  logic [LW-1:0] next_line;

  assign hb_rise = hblank_i & ~hb_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hb_q      <= 1'b0;
      ofs_q     <= '0;
      next_line <= '0;
      addr_q    <= '0;
      stride_q  <= '0;
      len_q     <= '0;
    end else begin
      hb_q <= hblank_i;
      if (vblank_i) ofs_q <= ofs_i;
      if (frame_start_i)  next_line <= '0;
      else if (hb_rise)   next_line <= next_line + 1'b1;
      if (hb_rise) begin
        addr_q   <= line_addr(base_i, ofs_q, 16'(next_line), stride_i);
        stride_q <= stride_i;
        len_q    <= len_i;
      end
    end
  end

  // R9: the offset register moves only while vertical blank is high
  a_r9_ofs_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !vblank_i |=> $stable(ofs_q));

endmodule

// File: rtl/vlr_seq.sv
module vlr_seq
  import vlr_pkg::*;
#(
  parameter int RST_CYC   = 3,
  parameter int GUARD_CYC = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       hb_rise,
  input  logic       last_pop,
  output logic       iface_rst,
  output logic       cmd_wr,
  output logic       rd_en,
  output logic       underrun,
  output logic [1:0] widx
);

  localparam int CW = $clog2(RST_CYC + GUARD_CYC + 4) + 1;

  seq_st_e       st;
  logic [CW-1:0] cnt;
  logic          busy;

  assign busy = (st == S_RST) || (st == S_GRD) || (st == S_CMD) || (st == S_RD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      cnt      <= '0;
      underrun <= 1'b0;
    end else if (hb_rise) begin
      st  <= S_RST;
      cnt <= '0;
      if (busy && !last_pop) underrun <= 1'b1;
    end else begin
      case (st)
        S_RST: if (cnt == CW'(RST_CYC - 1)) begin
                 st <= S_GRD; cnt <= '0;
               end else cnt <= cnt + 1'b1;
        S_GRD: if (cnt == CW'(GUARD_CYC - 1)) begin
                 st <= S_CMD; cnt <= '0;
               end else cnt <= cnt + 1'b1;
        S_CMD: if (cnt == CW'(3)) begin
                 st <= S_RD; cnt <= '0;
               end else cnt <= cnt + 1'b1;
        S_RD:  if (last_pop) st <= S_DONE;
        default: ;
      endcase
    end
  end

  assign iface_rst = (st == S_RST);
  assign cmd_wr    = (st == S_CMD);
  assign rd_en     = (st == S_RD);
  assign widx      = cnt[1:0];

  // run-length counters used only by the assertions
  logic [CW-1:0] rst_run, grd_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_run <= '0;
      grd_run <= '0;
    end else begin
      if (!iface_rst)          rst_run <= '0;
      else if (rst_run != '1)  rst_run <= rst_run + 1'b1;
      if (iface_rst)           grd_run <= '0;
      else if (grd_run != '1)  grd_run <= grd_run + 1'b1;
    end
  end

  // R5: the reset pulse is at least RST_CYC cycles long
  a_r5_rst_min: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(iface_rst) |-> rst_run >= CW'(RST_CYC));
  // R6: the first command word follows exactly GUARD_CYC idle cycles
  a_r6_guard: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmd_wr) |-> grd_run == CW'(GUARD_CYC));
  // R1: a descriptor is written without gaps unless a new line aborts it
  a_r1_burst: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && widx != 2'd3 && !hb_rise) |=> cmd_wr);
  // R10: the underrun flag never clears
  a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    underrun |=> underrun);

endmodule

// File: rtl/vlr_reader.sv
module vlr_reader #(
  parameter int XW = 15
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          rd_en,
  input  logic          rd_empty,
  input  logic [XW-1:0] len,
  output logic          rd_pop,
  output logic          rd_last
);

  logic [XW-1:0] cnt;

  assign rd_pop  = rd_en & ~rd_empty;
  assign rd_last = rd_pop && (cnt == len - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (start)   cnt <= '0;
    else if (rd_pop)  cnt <= cnt + 1'b1;
  end

  // R7: no pop beyond the line length
  a_r7_bound: assert property (@(posedge clk) disable iff (!rst_n)
    rd_pop |-> cnt < len);
  // R8: the last-word strobe is a single cycle
  a_r8_once: assert property (@(posedge clk) disable iff (!rst_n)
    rd_last |=> !rd_last);

endmodule

// File: rtl/vline_rdseq.sv
module vline_rdseq
  import vlr_pkg::*;
#(
  parameter int RST_CYC   = 3,
  parameter int GUARD_CYC = 2,
  parameter int LW        = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hblank_i,
  input  logic          vblank_i,
  input  logic          frame_start_i,
  input  logic [30:0]   base_addr_i,
  input  logic [30:0]   frame_ofs_i,
  input  logic [23:0]   stride_i,
  input  logic [14:0]   line_len_i,
  input  logic          rd_empty_i,
  output logic          iface_rst_o,
  output logic          cmd_wr_o,
  output logic [31:0]   cmd_data_o,
  output logic          rd_pop_o,
  output logic          rd_last_o,
  output logic          underrun_o
);

  logic          hb_rise, rd_en;
  logic [1:0]    widx;
  logic [AW-1:0] addr_q;
  logic [SW-1:0] stride_q;
  logic [XW-1:0] len_q;

  vlr_linegen #(.LW(LW)) u_line (
    .clk, .rst_n, .hblank_i, .vblank_i, .frame_start_i,
    .base_i(base_addr_i), .ofs_i(frame_ofs_i), .stride_i, .len_i(line_len_i),
    .hb_rise, .addr_q, .stride_q, .len_q
  );

  vlr_seq #(.RST_CYC(RST_CYC), .GUARD_CYC(GUARD_CYC)) u_seq (
    .clk, .rst_n, .hb_rise, .last_pop(rd_last_o),
    .iface_rst(iface_rst_o), .cmd_wr(cmd_wr_o), .rd_en,
    .underrun(underrun_o), .widx
  );

  vlr_reader #(.XW(XW)) u_rd (
    .clk, .rst_n, .start(hb_rise), .rd_en, .rd_empty(rd_empty_i),
    .len(len_q), .rd_pop(rd_pop_o), .rd_last(rd_last_o)
  );

  assign cmd_data_o = cmd_wr_o ? cmd_word(widx, len_q, addr_q, stride_q) : 32'd0;

  // R7: reads never share a cycle with a command write or a port reset
  a_r7_excl: assert property (@(posedge clk) disable iff (!rst_n)
    rd_pop_o |-> (!cmd_wr_o && !iface_rst_o));
  // R4: the top byte of words 2 and 3 is reserved zero
  a_r4_reserved: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr_o && widx[1]) |-> cmd_data_o[31:24] == 8'd0);
  // R2: word 0 has nothing above the length field
  a_r2_word0: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr_o && widx == 2'd0) |-> cmd_data_o[31:15] == 17'd0);

endmodule

// File: tb/sim_vline_rdseq.sv
module sim_vline_rdseq;

  localparam int RST_CYC = 3, GUARD_CYC = 2;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        hblank_i = 0, vblank_i = 0, frame_start_i = 0, rd_empty_i = 1;
  logic [30:0] base_addr_i = '0, frame_ofs_i = '0;
  logic [23:0] stride_i = '0;
  logic [14:0] line_len_i = 15'd1;
  logic        iface_rst_o, cmd_wr_o, rd_pop_o, rd_last_o, underrun_o;
  logic [31:0] cmd_data_o;

  vline_rdseq #(.RST_CYC(RST_CYC), .GUARD_CYC(GUARD_CYC), .LW(11)) u0 (.*);

  always #10 clk = ~clk;  // 50 MHz

  int n_chk = 0, n_fail = 0;

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic longint exp_addr(longint base, longint ofs, longint k, longint stride);
    return (base + ofs + k * stride) & 64'h7FFF_FFFF;
  endfunction

  function automatic longint exp_word(int i, longint len, longint addr, longint stride);
    case (i)
      0: return len & 64'h7FFF;
      1: return addr;  // read flag (bit 31) zero
      2: return 0;
      default: return stride & 64'hFF_FFFF;
    endcase
  endfunction

  // monitor and read-FIFO model
  int rst_run = 0, rst_seen = 0, gap = 0, gap_seen = 0, ncmd = 0;
  int npop = 0, nlast = 0, last_at = 0, prev_npop = 0, prev_nlast = 0, bad_pop = 0;
  int avail = 0, fill_dly = 0, stall_pct = 0;
  bit gap_on = 0, cmd_bad = 0, rst_prev = 0, cmd_prev = 0, force_empty = 0;
  logic [31:0] cw [4];

  initial begin
    forever begin
      @(negedge clk);
      rd_empty_i = force_empty || (avail == 0) || (($urandom % 100) < stall_pct);
      #5;
      if (iface_rst_o && !rst_prev) begin
        prev_npop = npop; prev_nlast = nlast;
        npop = 0; nlast = 0; last_at = 0; ncmd = 0; cmd_bad = 0;
        avail = 0; fill_dly = 0;
      end
      if (iface_rst_o) begin
        rst_run++; gap_on = 0;
      end else begin
        if (rst_run != 0) begin rst_seen = rst_run; rst_run = 0; gap = 0; gap_on = 1; end
        if (gap_on) begin
          if (cmd_wr_o) begin gap_seen = gap; gap_on = 0; end
          else gap++;
        end
      end
      if (fill_dly > 0) begin
        fill_dly--;
        if (fill_dly == 0) avail = int'(cw[0][14:0]);
      end
      if (cmd_wr_o) begin
        if (ncmd > 0 && !cmd_prev) cmd_bad = 1;
        if (ncmd < 4) cw[ncmd] = cmd_data_o;
        ncmd++;
        if (ncmd == 4) fill_dly = 3;
      end
      if (rd_pop_o) begin
        if (rd_empty_i) bad_pop++;
        npop++;
        if (avail > 0) avail--;
        if (rd_last_o) begin nlast++; last_at = npop; end
      end else if (rd_last_o) bad_pop++;
      rst_prev = iface_rst_o; cmd_prev = cmd_wr_o;
    end
  end

  task automatic pulse_hblank();
    @(negedge clk); hblank_i = 1'b1;
    repeat (3) @(negedge clk);
    hblank_i = 1'b0;
  endtask

  task automatic wait_pops(input int n);
    int t = 0;
    while (npop < n && t < 5000) begin @(negedge clk); t++; end
    repeat (4) @(negedge clk);
  endtask

  task automatic check_line(longint len, longint base, longint stride, longint ofs, longint k);
    longint a;
    a = exp_addr(base, ofs, k, stride);
    chk("R5", "reset pulse length", rst_seen, RST_CYC);
    chk("R6", "guard cycles", gap_seen, GUARD_CYC);
    chk("R1", "command word count", ncmd, 4);
    chk("R1", "command words contiguous", cmd_bad, 0);
    chk("R2", "word 0", cw[0], exp_word(0, len, a, stride));
    chk("R3", "word 1", cw[1], exp_word(1, len, a, stride));
    chk("R4", "word 2", cw[2], exp_word(2, len, a, stride));
    chk("R4", "word 3", cw[3], exp_word(3, len, a, stride));
    chk("R7", "pops in line", npop, len);
    chk("R7", "pops while empty", bad_pop, 0);
    chk("R8", "last strobes", nlast, 1);
    chk("R8", "last position", last_at, len);
  endtask

  task automatic set_line(longint len, longint base, longint stride);
    @(negedge clk);
    line_len_i = 15'(len); base_addr_i = 31'(base); stride_i = 24'(stride);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int seed, k;
    longint ofs_cur, len, base, stride;
    seed = $urandom(32'd7741);
    k = 0; ofs_cur = 0;
    repeat (3) @(negedge clk);
    #5;
    chk("R11", "iface_rst in reset", iface_rst_o, 0);
    rst_n = 1'b1;
    @(negedge clk); #5;
    chk("R11", "iface_rst", iface_rst_o, 0);
    chk("R11", "cmd_wr", cmd_wr_o, 0);
    chk("R11", "cmd_data", cmd_data_o, 0);
    chk("R11", "rd_pop", rd_pop_o, 0);
    chk("R11", "rd_last", rd_last_o, 0);
    chk("R11", "underrun", underrun_o, 0);

    for (int f = 0; f < 2; f++) begin
      @(negedge clk);
      vblank_i = 1'b1; frame_ofs_i = 31'($urandom);
      ofs_cur = frame_ofs_i;
      repeat (2) @(negedge clk);
      vblank_i = 1'b0; frame_start_i = 1'b1;
      @(negedge clk);
      frame_start_i = 1'b0;
      frame_ofs_i = 31'($urandom);  // R9: ignored outside vertical blank
      k = 0;
      stall_pct = (f == 0) ? 0 : 30;
      for (int l = 0; l < 6; l++) begin
        len = (f == 0 && l == 0) ? 1 : 1 + ($urandom % 40);
        base = $urandom & 32'h7FFF_FFFF;
        stride = $urandom & 32'hFF_FFFF;
        set_line(len, base, stride);
        pulse_hblank();
        wait_pops(int'(len));
        check_line(len, base, stride, ofs_cur, k);
        if (l == 2) chk("R9", "start address ignores active-video offset change",
                        cw[1], exp_addr(base, ofs_cur, k, stride));
        k++;
      end
    end

    // R10 corner: final pop and new blank edge in the same cycle
    stall_pct = 0;
    len = 4; base = 31'h0100_0000; stride = 24'h001E00;
    set_line(len, base, stride);
    force_empty = 1'b1;
    pulse_hblank();
    repeat (12) @(negedge clk);
    force_empty = 1'b0;
    while (npop < 3) @(negedge clk);
    hblank_i = 1'b1;
    repeat (3) @(negedge clk);
    hblank_i = 1'b0;
    chk("R10", "pops of line ending on blank edge", prev_npop, 4);
    chk("R8", "last strobe on coinciding pop", prev_nlast, 1);
    chk("R10", "no underrun when final pop meets edge", underrun_o, 0);
    k++;
    wait_pops(int'(len));
    check_line(len, base, stride, ofs_cur, k);
    k++;

    // R10: edge arrives while the line has not read anything
    force_empty = 1'b1;
    pulse_hblank();
    repeat (15) @(negedge clk);
    #5;
    chk("R10", "underrun low before abort", underrun_o, 0);
    k++;
    pulse_hblank();
    repeat (2) @(negedge clk);
    #5;
    chk("R10", "underrun raised", underrun_o, 1);
    chk("R10", "abandoned line pops", prev_npop, 0);
    force_empty = 1'b0;
    wait_pops(int'(len));
    check_line(len, base, stride, ofs_cur, k);
    #5;
    chk("R10", "underrun sticky", underrun_o, 1);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule